// File: doc/BRIEF.md
# Byte FIFO With Pseudo-DMA Port

This block buffers bytes between a host bus and the data path of a SCSI-style bus controller. The host reaches it through two routes. One is a byte-wide register port that pushes or pops one byte per access. The other is a pseudo-DMA port that moves one or two bytes per access. A command-mode input sends incoming bytes to a separate command buffer instead of the data FIFO, so the controller can collect a command block. A command sequencer reads that buffer through an indexed read port.

The FIFO is linear rather than circular. Its write position only moves forward. Both positions return to zero when a read empties the FIFO or when a flush arrives. The pseudo-DMA port works against an external transfer counter: each byte the counter admits is reported on a decrement output. A data-request output tells the host whether to keep moving data. The block drops it when the count runs out, when the FIFO fills on a pseudo-DMA write, or when a pseudo-DMA read leaves the FIFO empty. Bytes that cannot be stored raise a one-cycle overrun pulse.

Top module: `pdma_byte_fifo`

## Requirements
- R1: A register-port write appends one byte and raises `fifo_level` by one. When the write position is DEPTH-1 or higher, the byte is discarded, the level is unchanged, and `overrun` pulses for one cycle.
- R2: A register-port read with bytes present pops the oldest byte into `reg_rd_data` and lowers the level by one. A read that empties the FIFO returns both positions to zero, so the next write lands at position 0.
- R3: A pop of any byte slot from an empty FIFO returns the last byte read through either port. It leaves the level unchanged and raises no overrun.
- R4: A pseudo-DMA write with `pd_wide`=1 stores bits [15:8] first and then bits [7:0]. With `pd_wide`=0 it stores bits [7:0] only.
- R5: A pseudo-DMA read with `pd_wide`=1 puts the first popped byte in `pd_rd_data[15:8]` and the second in [7:0]. With `pd_wide`=0 it puts the byte in [7:0] and drives [15:8] to zero.
- R6: During a pseudo-DMA write, byte slot i (0 = first) is admitted only when `tc_count` > i. `tc_dec` equals the number of admitted bytes, and it is combinational from `tc_count`, `pd_wr_en` and `pd_wide`. Bytes that are not admitted are discarded with no overrun.
- R7: `drq_set` raises `drq`. After a pseudo-DMA write, `drq` drops if `tc_count - tc_dec` is zero or the FIFO write position has reached DEPTH. An admitted byte that meets a write position of DEPTH is discarded and pulses `overrun`.
- R8: After a pseudo-DMA read, `drq` drops if the FIFO is empty.
- R9: With `cmd_mode`=1, bytes from both write ports go into the command buffer in arrival order, and the FIFO is left untouched. Once CMD_DEPTH bytes are held, further bytes are discarded and `overrun` pulses. Counter-admitted pseudo-DMA bytes still count in `tc_dec`. `cmd_clear` sets `cmd_len` to zero.
- R10: `flush` empties the FIFO and sets `fifo_level` to zero. It leaves `drq`, the command buffer and the last-read byte unchanged.
- R11: After reset, `fifo_level`, `cmd_len`, `drq`, `overrun`, `reg_rd_data` and `pd_rd_data` are all zero.
- R12: At most one of `flush`, `drq_set`, `cmd_clear`, `reg_wr_en`, `reg_rd_en`, `pd_wr_en` and `pd_rd_en` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_mode | input | 1 | Steer written bytes into the command buffer |
| flush | input | 1 | Empty the FIFO |
| drq_set | input | 1 | Raise the data request |
| cmd_clear | input | 1 | Empty the command buffer |
| reg_wr_en | input | 1 | Register-port byte write |
| reg_wr_data | input | 8 | Register-port write byte |
| reg_rd_en | input | 1 | Register-port byte read |
| reg_rd_data | output | 8 | Byte returned by the last register-port read |
| pd_wr_en | input | 1 | Pseudo-DMA write |
| pd_rd_en | input | 1 | Pseudo-DMA read |
| pd_wide | input | 1 | 1 = two-byte access, 0 = one byte |
| pd_wr_data | input | 16 | Pseudo-DMA write data |
| pd_rd_data | output | 16 | Data returned by the last pseudo-DMA read |
| tc_count | input | TC_W | Current external transfer count |
| tc_dec | output | 2 | Bytes to subtract from the external count |
| drq | output | 1 | Data request to the host |
| overrun | output | 1 | One-cycle pulse for a discarded byte |
| fifo_level | output | PW | Bytes held in the FIFO |
| cmd_len | output | CW | Bytes held in the command buffer |
| cmd_rd_idx | input | CIW | Command buffer read index |
| cmd_rd_data | output | 8 | Command buffer byte at `cmd_rd_idx` |

## Verification
Every registered result appears at the first rising edge after the access that causes it. This covers the level, the read data, `drq`, `overrun` and `cmd_len`. `tc_dec` and `cmd_rd_data` are combinational and are valid while their inputs are held. The bench applies each access on a falling edge and lets one rising edge pass. At the next falling edge it reads every output, with the access inputs still driven, and only then releases them. Each comparison therefore sees exactly one edge's worth of effect and a still-valid `tc_dec`.

// File: rtl/pdf_pkg.sv
// Shared types for the pseudo-DMA byte FIFO.
// Assumes byte-wide storage throughout.
package pdf_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pdf_fifo_store.sv
// Linear byte store with forward-only write and read positions.
// Takes up to two pushes or two pops per cycle; the caller keeps pushes in range.
// Both positions go to zero on flush, or when a pop makes them equal.
module pdf_fifo_store
    import pdf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [1:0]    push_n,
    input  byte_t         push_b0,
    input  byte_t         push_b1,
    input  logic [1:0]    pop_n,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output byte_t         peek0,
    output byte_t         peek1
);
    logic [DEPTH-1:0][BYTE_W-1:0] mem;
    logic [PW-1:0] wptr_q, rptr_q, nxt_w, nxt_r;

    // Write the pushed bytes into the cells at and after the write position.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push_n != 2'd0 && wptr_q == PW'(i))
                mem[i] <= push_b0;
            else if (push_n == 2'd2 && wptr_q + PW'(1) == PW'(i))
                mem[i] <= push_b1;
        end
    end

    // Show the two oldest bytes for popping.
    always_comb begin
        peek0 = '0;
        peek1 = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rptr_q == PW'(i))          peek0 = mem[i];
            if (rptr_q + PW'(1) == PW'(i)) peek1 = mem[i];
        end
    end

    // Work out the next positions.
    always_comb begin
        nxt_w = wptr_q + PW'(push_n);
        nxt_r = rptr_q + PW'(pop_n);
    end

    // Update the positions; they return to zero when the store empties.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else if (pop_n != 2'd0 && nxt_r == nxt_w) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            wptr_q <= nxt_w;
            rptr_q <= nxt_r;
        end
    end

    assign wptr = wptr_q;
    assign rptr = rptr_q;
endmodule

// File: rtl/pdf_cmd_store.sv
// Command byte buffer. Appends up to two bytes per cycle and has an indexed read port.
// The caller never pushes past CMD_DEPTH.
module pdf_cmd_store
    import pdf_pkg::*;
#(
    parameter int CMD_DEPTH = 32,
    localparam int CW  = $clog2(CMD_DEPTH + 1),
    localparam int CIW = $clog2(CMD_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic [1:0]     push_n,
    input  byte_t          push_b0,
    input  byte_t          push_b1,
    input  logic [CIW-1:0] rd_idx,
    output logic [CW-1:0]  len,
    output byte_t          rd_data
);
    logic [CMD_DEPTH-1:0][BYTE_W-1:0] mem;
    logic [CW-1:0] len_q;

    // Append the bytes at the current length.
    always_ff @(posedge clk) begin
        for (int i = 0; i < CMD_DEPTH; i++) begin
            if (push_n != 2'd0 && len_q == CW'(i))
                mem[i] <= push_b0;
            else if (push_n == 2'd2 && len_q + CW'(1) == CW'(i))
                mem[i] <= push_b1;
        end
    end

    // Track how many bytes the buffer holds.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) len_q <= '0;
        else                 len_q <= len_q + CW'(push_n);
    end

    assign len     = len_q;
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/pdf_xfer_ctrl.sv
// Decides how many bytes each access moves and where they go.
// Also owns the data request, the overrun pulse and the read-data registers.
// Assumes at most one access per cycle.
module pdf_xfer_ctrl
    import pdf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 32,
    parameter int TC_W      = 17,
    localparam int PW = $clog2(DEPTH + 1),
    localparam int CW = $clog2(CMD_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_mode,
    input  logic            drq_set,
    input  logic            reg_wr_en,
    input  byte_t           reg_wr_data,
    input  logic            reg_rd_en,
    input  logic            pd_wr_en,
    input  logic            pd_rd_en,
    input  logic            pd_wide,
    input  logic [15:0]     pd_wr_data,
    input  logic [TC_W-1:0] tc_count,
    input  logic [PW-1:0]   wptr,
    input  logic [PW-1:0]   rptr,
    input  logic [CW-1:0]   cmd_len,
    input  byte_t           peek0,
    input  byte_t           peek1,
    output logic [1:0]      fifo_push_n,
    output logic [1:0]      cmd_push_n,
    output byte_t           push_b0,
    output byte_t           push_b1,
    output logic [1:0]      pop_n,
    output logic [1:0]      tc_dec,
    output logic            drq,
    output logic            overrun,
    output byte_t           reg_rd_data,
    output logic [15:0]     pd_rd_data
);
    int in_n, ok_n, room_n, st_n, rd_n, avail_n, pop_i, wp_i, tc_i;
    logic  wr_ovr, pd_wr, pd_rd, cnt_out, full_after, empty_after;
    byte_t slot0, slot1, last_q, reg_rd_q;
    logic [15:0] pd_rd_q;
    logic drq_q, ovr_q;

    assign pd_wr = pd_wr_en && !reg_wr_en;
    assign pd_rd = pd_rd_en && !reg_rd_en;

    // Write side: offered bytes, counter admission, room and destination.
    always_comb begin
        wp_i = int'(wptr);
        tc_i = int'(tc_count);
        in_n = 0;
        if (reg_wr_en)  in_n = 1;
        else if (pd_wr) in_n = pd_wide ? 2 : 1;
        ok_n = in_n;
        if (pd_wr && tc_i < in_n) ok_n = tc_i;
        if (cmd_mode)       room_n = CMD_DEPTH - int'(cmd_len);
        else if (reg_wr_en) room_n = (wp_i >= DEPTH - 1) ? 0 : 1;
        else                room_n = DEPTH - wp_i;
        st_n   = (ok_n < room_n) ? ok_n : room_n;
        wr_ovr = ok_n > room_n;
        push_b0 = reg_wr_en ? reg_wr_data : (pd_wide ? pd_wr_data[15:8] : pd_wr_data[7:0]);
        push_b1 = pd_wr_data[7:0];
        fifo_push_n = cmd_mode ? 2'd0 : 2'(st_n);
        cmd_push_n  = cmd_mode ? 2'(st_n) : 2'd0;
        tc_dec      = pd_wr ? 2'(ok_n) : 2'd0;
        cnt_out     = (tc_i - ok_n) == 0;
        full_after  = !cmd_mode && (wp_i + st_n == DEPTH);
    end

    // Read side: bytes popped, with an empty slot replaying the last byte read.
    always_comb begin
        avail_n = int'(wptr) - int'(rptr);
        rd_n = 0;
        if (reg_rd_en)  rd_n = 1;
        else if (pd_rd) rd_n = pd_wide ? 2 : 1;
        pop_i = (rd_n < avail_n) ? rd_n : avail_n;
        pop_n = 2'(pop_i);
        slot0 = (avail_n > 0) ? peek0 : last_q;
        slot1 = (avail_n > 1) ? peek1 : slot0;
        empty_after = (avail_n - pop_i) == 0;
    end

    // Keep the read-data registers and the last byte read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q   <= '0;
            reg_rd_q <= '0;
            pd_rd_q  <= '0;
        end else if (reg_rd_en) begin
            reg_rd_q <= slot0;
            last_q   <= slot0;
        end else if (pd_rd) begin
            pd_rd_q <= pd_wide ? {slot0, slot1} : {8'h00, slot0};
            last_q  <= pd_wide ? slot1 : slot0;
        end
    end

    // Data request: dropping takes priority over raising.
    always_ff @(posedge clk) begin
        if (!rst_n)                           drq_q <= 1'b0;
        else if (pd_wr && (cnt_out || full_after)) drq_q <= 1'b0;
        else if (pd_rd && empty_after)        drq_q <= 1'b0;
        else if (drq_set)                     drq_q <= 1'b1;
    end

    // Overrun pulse for any admitted byte that could not be stored.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr_q <= 1'b0;
        else        ovr_q <= (reg_wr_en || pd_wr) && wr_ovr;
    end

    assign drq         = drq_q;
    assign overrun     = ovr_q;
    assign reg_rd_data = reg_rd_q;
    assign pd_rd_data  = pd_rd_q;
endmodule

// File: rtl/pdma_byte_fifo.sv
// Top of the byte FIFO with register and pseudo-DMA ports.
// Connects the transfer control, the data store and the command buffer.
// The external transfer counter subtracts tc_dec on each clock.
module pdma_byte_fifo
    import pdf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 32,
    parameter int TC_W      = 17,
    localparam int PW  = $clog2(DEPTH + 1),
    localparam int CW  = $clog2(CMD_DEPTH + 1),
    localparam int CIW = $clog2(CMD_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_mode,
    input  logic            flush,
    input  logic            drq_set,
    input  logic            cmd_clear,
    input  logic            reg_wr_en,
    input  logic [7:0]      reg_wr_data,
    input  logic            reg_rd_en,
    output logic [7:0]      reg_rd_data,
    input  logic            pd_wr_en,
    input  logic            pd_rd_en,
    input  logic            pd_wide,
    input  logic [15:0]     pd_wr_data,
    output logic [15:0]     pd_rd_data,
    input  logic [TC_W-1:0] tc_count,
    output logic [1:0]      tc_dec,
    output logic            drq,
    output logic            overrun,
    output logic [PW-1:0]   fifo_level,
    output logic [CW-1:0]   cmd_len,
    input  logic [CIW-1:0]  cmd_rd_idx,
    output logic [7:0]      cmd_rd_data
);
    logic [PW-1:0] wptr, rptr;
    logic [1:0]    fifo_push_n, cmd_push_n, pop_n;
    byte_t         push_b0, push_b1, peek0, peek1;

    pdf_xfer_ctrl #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .TC_W(TC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_mode(cmd_mode), .drq_set(drq_set),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_en(reg_rd_en),
        .pd_wr_en(pd_wr_en), .pd_rd_en(pd_rd_en), .pd_wide(pd_wide),
        .pd_wr_data(pd_wr_data), .tc_count(tc_count), .wptr(wptr), .rptr(rptr),
        .cmd_len(cmd_len), .peek0(peek0), .peek1(peek1),
        .fifo_push_n(fifo_push_n), .cmd_push_n(cmd_push_n),
        .push_b0(push_b0), .push_b1(push_b1), .pop_n(pop_n), .tc_dec(tc_dec),
        .drq(drq), .overrun(overrun), .reg_rd_data(reg_rd_data),
        .pd_rd_data(pd_rd_data)
    );

    pdf_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_n(fifo_push_n),
        .push_b0(push_b0), .push_b1(push_b1), .pop_n(pop_n),
        .wptr(wptr), .rptr(rptr), .peek0(peek0), .peek1(peek1)
    );

    pdf_cmd_store #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
        .clk(clk), .rst_n(rst_n), .clear(cmd_clear), .push_n(cmd_push_n),
        .push_b0(push_b0), .push_b1(push_b1), .rd_idx(cmd_rd_idx),
        .len(cmd_len), .rd_data(cmd_rd_data)
    );

    assign fifo_level = wptr - rptr;
endmodule

// File: rtl/pdma_byte_fifo_chk.sv
// Checker for pdma_byte_fifo, attached with bind. Relates ports over time.
module pdma_byte_fifo_chk #(
    parameter int DEPTH     = 16,
    parameter int CMD_DEPTH = 32,
    parameter int TC_W      = 17,
    localparam int PW = $clog2(DEPTH + 1),
    localparam int CW = $clog2(CMD_DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            flush,
    input logic            drq_set,
    input logic            cmd_clear,
    input logic            reg_wr_en,
    input logic            reg_rd_en,
    input logic            pd_wr_en,
    input logic            pd_rd_en,
    input logic            pd_wide,
    input logic [TC_W-1:0] tc_count,
    input logic [1:0]      tc_dec,
    input logic            drq,
    input logic            overrun,
    input logic [PW-1:0]   fifo_level,
    input logic [CW-1:0]   cmd_len
);
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
    localparam logic [CW-1:0] CMD_V   = CW'(CMD_DEPTH);
    logic [TC_W-1:0] dec_ext;
    assign dec_ext = {{(TC_W-2){1'b0}}, tc_dec};

    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= DEPTH_V);
    assert_overrun_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(reg_wr_en || pd_wr_en));
    assert_reg_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && fifo_level != '0) |=> fifo_level == $past(fifo_level) - PW'(1));
    assert_dec_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_wr_en |-> tc_dec == 2'd0);
    assert_dec_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_wr_en && !pd_wide) |-> tc_dec <= 2'd1);
    assert_count_drops_drq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_wr_en && tc_count == dec_ext) |=> !drq);
    assert_read_drops_drq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pd_rd_en |=> (fifo_level != '0 || !drq));
    assert_cmd_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_len <= CMD_V);
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fifo_level == '0);
    assert_one_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush, drq_set, cmd_clear, reg_wr_en, reg_rd_en, pd_wr_en, pd_rd_en}));
endmodule

bind pdma_byte_fifo pdma_byte_fifo_chk #(.DEPTH(DEPTH), .CMD_DEPTH(CMD_DEPTH), .TC_W(TC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .drq_set(drq_set), .cmd_clear(cmd_clear),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .pd_wr_en(pd_wr_en),
    .pd_rd_en(pd_rd_en), .pd_wide(pd_wide), .tc_count(tc_count), .tc_dec(tc_dec),
    .drq(drq), .overrun(overrun), .fifo_level(fifo_level), .cmd_len(cmd_len)
);

// File: tb/pdma_byte_fifo_bench.sv
`timescale 1ns/1ps
module pdma_byte_fifo_bench;
    localparam int DEPTH = 16, CMD_DEPTH = 32, TC_W = 17;
    localparam int PW = $clog2(DEPTH + 1), CW = $clog2(CMD_DEPTH + 1), CIW = $clog2(CMD_DEPTH);

    localparam logic [2:0] OP_IDLE = 3'd0, OP_REGW = 3'd1, OP_REGR = 3'd2, OP_PDW = 3'd3,
                           OP_PDR = 3'd4, OP_FLUSH = 3'd5, OP_DRQS = 3'd6, OP_CCLR = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic        wide;
        logic [15:0] data;
        logic [16:0] tc;
        logic [4:0]  lvl;
        logic [15:0] rd;
        logic [1:0]  dec;
        logic        drq;
        logic        ovr;
        logic [7:0]  req;
    } vec_t;

    // op, wide, data, tc | expected level, read data, dec, drq, overrun | requirement
    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{OP_DRQS, 1'b0, 16'h0000, 17'd0, 5'd0, 16'h0000, 2'd0, 1'b1, 1'b0, 8'd7},  // R7 raise
        '{OP_REGW, 1'b0, 16'h0011, 17'd0, 5'd1, 16'h0000, 2'd0, 1'b1, 1'b0, 8'd1},  // R1
        '{OP_REGW, 1'b0, 16'h0022, 17'd0, 5'd2, 16'h0000, 2'd0, 1'b1, 1'b0, 8'd1},  // R1
        '{OP_REGR, 1'b0, 16'h0000, 17'd0, 5'd1, 16'h0011, 2'd0, 1'b1, 1'b0, 8'd2},  // R2
        '{OP_REGR, 1'b0, 16'h0000, 17'd0, 5'd0, 16'h0022, 2'd0, 1'b1, 1'b0, 8'd2},  // R2
        '{OP_REGR, 1'b0, 16'h0000, 17'd0, 5'd0, 16'h0022, 2'd0, 1'b1, 1'b0, 8'd3},  // R3 empty
        '{OP_PDW,  1'b1, 16'hA1B2, 17'd5, 5'd2, 16'h0000, 2'd2, 1'b1, 1'b0, 8'd4},  // R4
        '{OP_PDR,  1'b1, 16'h0000, 17'd0, 5'd0, 16'hA1B2, 2'd0, 1'b0, 1'b0, 8'd5},  // R5, R8
        '{OP_DRQS, 1'b0, 16'h0000, 17'd0, 5'd0, 16'h0000, 2'd0, 1'b1, 1'b0, 8'd7},
        '{OP_PDW,  1'b0, 16'h0033, 17'd1, 5'd1, 16'h0000, 2'd1, 1'b0, 1'b0, 8'd7},  // R7 count out
        '{OP_PDW,  1'b1, 16'h4455, 17'd1, 5'd2, 16'h0000, 2'd1, 1'b0, 1'b0, 8'd6},  // R6 one admitted
        '{OP_PDR,  1'b0, 16'h0000, 17'd0, 5'd1, 16'h0033, 2'd0, 1'b0, 1'b0, 8'd5},  // R5 narrow
        '{OP_PDR,  1'b1, 16'h0000, 17'd0, 5'd0, 16'h4444, 2'd0, 1'b0, 1'b0, 8'd3},  // R3 replay
        '{OP_DRQS, 1'b0, 16'h0000, 17'd0, 5'd0, 16'h0000, 2'd0, 1'b1, 1'b0, 8'd7},
        '{OP_PDW,  1'b1, 16'h7788, 17'd0, 5'd0, 16'h0000, 2'd0, 1'b0, 1'b0, 8'd6},  // R6 zero count
        '{OP_REGW, 1'b0, 16'h0001, 17'd0, 5'd1, 16'h0000, 2'd0, 1'b0, 1'b0, 8'd1},
        '{OP_REGW, 1'b0, 16'h0002, 17'd0, 5'd2, 16'h0000, 2'd0, 1'b0, 1'b0, 8'd1},
        '{OP_FLUSH,1'b0, 16'h0000, 17'd0, 5'd0, 16'h0000, 2'd0, 1'b0, 1'b0, 8'd10}, // R10
        '{OP_REGR, 1'b0, 16'h0000, 17'd0, 5'd0, 16'h0044, 2'd0, 1'b0, 1'b0, 8'd3},  // R3 last byte
        '{OP_REGW, 1'b0, 16'h0005, 17'd0, 5'd1, 16'h0000, 2'd0, 1'b0, 1'b0, 8'd10},
        '{OP_REGR, 1'b0, 16'h0000, 17'd0, 5'd0, 16'h0005, 2'd0, 1'b0, 1'b0, 8'd2}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_mode = 0, flush = 0, drq_set = 0, cmd_clear = 0;
    logic reg_wr_en = 0, reg_rd_en = 0, pd_wr_en = 0, pd_rd_en = 0, pd_wide = 0;
    logic [7:0] reg_wr_data = '0;
    logic [15:0] pd_wr_data = '0;
    logic [TC_W-1:0] tc_count = '0;
    logic [CIW-1:0] cmd_rd_idx = '0;
    logic [7:0] reg_rd_data, cmd_rd_data;
    logic [15:0] pd_rd_data;
    logic [1:0] tc_dec;
    logic drq, overrun;
    logic [PW-1:0] fifo_level;
    logic [CW-1:0] cmd_len;

    int checks = 0, errors = 0;
    logic s_drq, s_ovr;
    logic [1:0] s_dec;
    logic [PW-1:0] s_lvl;
    logic [7:0] s_reg;
    logic [15:0] s_pd;
    logic [CW-1:0] s_clen;
    bit done = 0;

    always #5 clk = ~clk;

    pdma_byte_fifo u_pdma_byte_fifo (
        .clk(clk), .rst_n(rst_n), .cmd_mode(cmd_mode), .flush(flush), .drq_set(drq_set),
        .cmd_clear(cmd_clear), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data), .pd_wr_en(pd_wr_en),
        .pd_rd_en(pd_rd_en), .pd_wide(pd_wide), .pd_wr_data(pd_wr_data),
        .pd_rd_data(pd_rd_data), .tc_count(tc_count), .tc_dec(tc_dec), .drq(drq),
        .overrun(overrun), .fifo_level(fifo_level), .cmd_len(cmd_len),
        .cmd_rd_idx(cmd_rd_idx), .cmd_rd_data(cmd_rd_data)
    );

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Apply one access at a falling edge, let one rising edge pass, sample, then release.
    task automatic run_op(input logic [2:0] op, input logic wide, input logic [15:0] data,
                          input logic [TC_W-1:0] tc);
        pd_wide = wide; tc_count = tc; reg_wr_data = data[7:0]; pd_wr_data = data;
        reg_wr_en = (op == OP_REGW); reg_rd_en = (op == OP_REGR);
        pd_wr_en = (op == OP_PDW);   pd_rd_en = (op == OP_PDR);
        flush = (op == OP_FLUSH);    drq_set = (op == OP_DRQS); cmd_clear = (op == OP_CCLR);
        @(negedge clk);
        s_drq = drq; s_ovr = overrun; s_dec = tc_dec; s_lvl = fifo_level;
        s_reg = reg_rd_data; s_pd = pd_rd_data; s_clen = cmd_len;
        reg_wr_en = 0; reg_rd_en = 0; pd_wr_en = 0; pd_rd_en = 0;
        flush = 0; drq_set = 0; cmd_clear = 0; pd_wide = 0; tc_count = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(11, "level", 32'(fifo_level), 0);
        chk(11, "drq", 32'(drq), 0);
        chk(11, "overrun", 32'(overrun), 0);
        chk(11, "reg data", 32'(reg_rd_data), 0);
        chk(11, "pd data", 32'(pd_rd_data), 0);
        chk(11, "cmd len", 32'(cmd_len), 0);

        // Table walk (one access per cycle: R12)
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].op, VEC[i].wide, VEC[i].data, VEC[i].tc);
            chk(int'(VEC[i].req), $sformatf("vec%0d level", i), 32'(s_lvl), 32'(VEC[i].lvl));
            chk(int'(VEC[i].req), $sformatf("vec%0d drq", i), 32'(s_drq), 32'(VEC[i].drq));
            chk(int'(VEC[i].req), $sformatf("vec%0d overrun", i), 32'(s_ovr), 32'(VEC[i].ovr));
            chk(int'(VEC[i].req), $sformatf("vec%0d dec", i), 32'(s_dec), 32'(VEC[i].dec));
            if (VEC[i].op == OP_REGR)
                chk(int'(VEC[i].req), $sformatf("vec%0d reg data", i), 32'(s_reg), 32'(VEC[i].rd[7:0]));
            if (VEC[i].op == OP_PDR)
                chk(int'(VEC[i].req), $sformatf("vec%0d pd data", i), 32'(s_pd), 32'(VEC[i].rd));
        end

        // R1: the register port fills to DEPTH-1, then the next write is refused
        for (int i = 0; i < DEPTH - 1; i++) begin
            run_op(OP_REGW, 0, 16'(8'h80 + i), 0);
            chk(1, "fill level", 32'(s_lvl), 32'(i + 1));
        end
        chk(1, "fill no overrun", 32'(s_ovr), 0);
        run_op(OP_REGW, 0, 16'h009F, 0);
        chk(1, "refused overrun", 32'(s_ovr), 1);
        chk(1, "refused level", 32'(s_lvl), 32'(DEPTH - 1));
        // R7: a pseudo-DMA write reaches full and drops drq; one more byte overruns
        run_op(OP_DRQS, 0, 0, 0);
        run_op(OP_PDW, 0, 16'h00EE, 10);
        chk(7, "full level", 32'(s_lvl), 32'(DEPTH));
        chk(7, "full drops drq", 32'(s_drq), 0);
        chk(6, "full dec", 32'(s_dec), 1);
        run_op(OP_PDW, 0, 16'h00EF, 9);
        chk(7, "full overrun", 32'(s_ovr), 1);
        chk(7, "full still level", 32'(s_lvl), 32'(DEPTH));
        chk(6, "dropped byte still counted", 32'(s_dec), 1);
        // R2: drain in order
        for (int i = 0; i < DEPTH - 1; i++) begin
            run_op(OP_REGR, 0, 0, 0);
            chk(2, "drain data", 32'(s_reg), 32'(8'h80 + i));
        end
        run_op(OP_REGR, 0, 0, 0);
        chk(2, "drain last", 32'(s_reg), 32'h00EE);
        chk(2, "drain level", 32'(s_lvl), 0);
        run_op(OP_REGW, 0, 16'h005A, 0);
        chk(2, "restart level", 32'(s_lvl), 1);
        chk(2, "restart no overrun", 32'(s_ovr), 0);
        run_op(OP_FLUSH, 0, 0, 0);

        // R9: command mode steering, ordering and overflow
        cmd_mode = 1;
        run_op(OP_REGW, 0, 16'h0012, 0);
        chk(9, "cmd len 1", 32'(s_clen), 1);
        chk(9, "fifo untouched", 32'(s_lvl), 0);
        run_op(OP_PDW, 1, 16'h3456, 100);
        chk(9, "cmd len 3", 32'(s_clen), 3);
        chk(6, "cmd dec", 32'(s_dec), 2);
        cmd_rd_idx = 0; #1; chk(9, "cmd byte0", 32'(cmd_rd_data), 32'h12);
        cmd_rd_idx = 1; #1; chk(4, "cmd byte1 high first", 32'(cmd_rd_data), 32'h34);
        cmd_rd_idx = 2; #1; chk(4, "cmd byte2 low second", 32'(cmd_rd_data), 32'h56);
        @(negedge clk);
        for (int i = 3; i < CMD_DEPTH; i++) run_op(OP_REGW, 0, 16'(i), 0);
        chk(9, "cmd full len", 32'(s_clen), 32'(CMD_DEPTH));
        chk(9, "cmd full no overrun", 32'(s_ovr), 0);
        run_op(OP_REGW, 0, 16'h00FF, 0);
        chk(9, "cmd overflow", 32'(s_ovr), 1);
        chk(9, "cmd overflow len", 32'(s_clen), 32'(CMD_DEPTH));
        run_op(OP_PDW, 1, 16'hCAFE, 5);
        chk(9, "cmd pd overflow", 32'(s_ovr), 1);
        chk(9, "cmd pd overflow dec", 32'(s_dec), 2);
        run_op(OP_CCLR, 0, 0, 0);
        chk(9, "cmd clear", 32'(s_clen), 0);
        cmd_mode = 0;
        run_op(OP_IDLE, 0, 0, 0);
        chk(10, "fifo still empty", 32'(s_lvl), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule